// File: doc/BRIEF.md
# Configuration-Space Aperture Decoder

This block sits behind a base address register that software has set up to expose an endpoint's 4 KB configuration space as ordinary memory. Every incoming memory request is presented with its address, length in DWords, direction, write data and byte enables. The block compares the address against the programmed base and checks that the request is exactly one DWord long. It then drives read or write strobes, along with a DWord register index, into an internal register file.

The base can be a single 32-bit register or a pair of registers that together form a 64-bit base. When the setup mode selects configuration-space mapping, the aperture is always 4 KB and the programmed limit plays no part. In any other mode the block stays silent, because address-window decoding is handled elsewhere. A request that hits the aperture with an illegal length touches no register and sets an error flag that holds until reset.

Top module: `cfgbar_decoder`

## Requirements
- R1: A request can hit only while `bar_mode_i` equals 2'b01 (configuration-space mapping). With 2'b00, 2'b10 or 2'b11, `hit_o`, `rd_stb_o` and `wr_stb_o` stay low.
- R2: The aperture is 4 KB. Address bits [31:12] must equal `bar0_base_i[31:12]`, and address bits [11:0] and `bar0_base_i[11:0]` do not affect the hit.
- R3: `bar_limit_i` has no effect on the hit decision, the index or the strobes in configuration-space mode.
- R4: With `bar_pair64_i` low, a hit also requires address bits [63:32] to be zero.
- R5: With `bar_pair64_i` high, a hit also requires address bits [63:32] to equal `bar1_base_i`.
- R6: The outputs `hit_o`, `reg_idx_o`, `rd_stb_o` and `wr_stb_o` appear on the clock edge after the request is sampled. `reg_idx_o` equals address bits [11:2], and read and write strobes are never high together.
- R7: A hitting request with `req_len_i` other than 1 raises no strobe and sets `len_err_o`. `len_err_o` then stays high until reset.
- R8: A request that misses the aperture raises no strobe and leaves `len_err_o` unchanged.
- R9: A write updates only the byte lanes whose enable is set. Enable bit k maps to register bits [8k+7:8k].
- R10: A read returns the whole stored DWord on `rdata_o`, in the same cycle as `rd_stb_o`, whatever the byte enables are.
- R11: An index at or above `REG_WORDS` (default 256) is discarded on write and reads back as zero.
- R12: While `rst_ni` is low and after it is released, all outputs are low and every register holds zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_addr_i | input | 64 | Request byte address |
| req_len_i | input | 10 | Request length in DWords |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 32 | Write data, little-endian lanes |
| req_be_i | input | 4 | Byte enables |
| bar_mode_i | input | 2 | Setup mode, 2'b01 = configuration space |
| bar0_base_i | input | 32 | Low base register |
| bar1_base_i | input | 32 | High base register used when paired |
| bar_pair64_i | input | 1 | Pair both registers into a 64-bit base |
| bar_limit_i | input | 64 | Programmed limit, ignored in this mode |
| hit_o | output | 1 | Previous request hit the aperture |
| reg_idx_o | output | 10 | DWord register index of the last hit |
| rd_stb_o | output | 1 | Register read performed |
| wr_stb_o | output | 1 | Register write performed |
| rdata_o | output | 32 | Read data, valid with `rd_stb_o` |
| len_err_o | output | 1 | Sticky illegal-length flag |

## Verification
An aperture hit and a length violation can land in the same cycle. In that cycle `hit_o` rises and `len_err_o` is set, while both strobes must stay low and the register file must stay unchanged. Random traffic aimed at the aperture mixes in lengths of 0, 2 and 3 next to legal single-DWord requests. A directed sequence places a bad-length hit between a write and a read-back of the same word. The bench model judges each cycle, and the read-back proves that the rejected write left no trace.

// File: rtl/cfgbar_pkg.sv
package cfgbar_pkg;
  localparam int unsigned ADDR_W = 64;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BE_W   = DATA_W / 8;
  localparam int unsigned OFS_W  = 12;
  localparam int unsigned IDX_W  = OFS_W - 2;
  localparam int unsigned LEN_W  = 10;
  localparam int unsigned HALF_W = ADDR_W / 2;

  typedef enum logic [1:0] {
    BAR_OFF   = 2'b00,
    BAR_CFG   = 2'b01,
    BAR_MEM32 = 2'b10,
    BAR_MEM64 = 2'b11
  } bar_mode_e;

  typedef struct packed {
    logic             hit;
    logic             rd;
    logic             wr;
    logic             bad_len;
    logic [IDX_W-1:0] idx;
  } dec_s;
endpackage

// File: rtl/cfgbar_match.sv
module cfgbar_match
  import cfgbar_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        mode_i,
  input  logic [HALF_W-1:0] base_lo_i,
  input  logic [HALF_W-1:0] base_hi_i,
  input  logic              pair64_i,
  input  logic [ADDR_W-1:0] limit_i,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] CFG_MASK = {{(ADDR_W-OFS_W){1'b0}}, {OFS_W{1'b1}}};

  logic              cfg_sel;
  logic [ADDR_W-1:0] ofs_mask;
  logic [ADDR_W-1:0] base_full;

  always_comb begin
    cfg_sel   = (mode_i == BAR_CFG);
    // config mode forces a 4 KB window; limit only shapes other modes
    ofs_mask  = cfg_sel ? CFG_MASK : limit_i;
    base_full = {pair64_i ? base_hi_i : {HALF_W{1'b0}}, base_lo_i};
    hit_o     = cfg_sel && ((addr_i & ~ofs_mask) == (base_full & ~ofs_mask));
  end
endmodule

// File: rtl/cfgbar_req.sv
module cfgbar_req
  import cfgbar_pkg::*;
(
  input  logic             valid_i,
  input  logic             we_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             match_i,
  input  logic [OFS_W-1:0] ofs_i,
  output dec_s             dec_o
);
  logic legal;

  always_comb begin
    legal         = (len_i == LEN_W'(1));
    dec_o.hit     = valid_i && match_i;
    dec_o.rd      = dec_o.hit && legal && !we_i;
    dec_o.wr      = dec_o.hit && legal && we_i;
    dec_o.bad_len = dec_o.hit && !legal;
    dec_o.idx     = ofs_i[OFS_W-1:2];
  end
endmodule

// File: rtl/cfgbar_regfile.sv
module cfgbar_regfile
  import cfgbar_pkg::*;
#(
  parameter int unsigned WORDS = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BE_W-1:0]   be_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned WA_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic            in_range;
  logic [WA_W-1:0] word_a;

  always_comb begin
    in_range = (32'(idx_i) < WORDS);
    word_a   = WA_W'(idx_i);
  end

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    logic [7:0] mem [WORDS];
    logic [7:0] rd_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int w = 0; w < WORDS; w++) mem[w] <= 8'h00;
        rd_q <= 8'h00;
      end else begin
        if (wr_en_i && in_range && be_i[g]) mem[word_a] <= wdata_i[8*g +: 8];
        if (rd_en_i) rd_q <= in_range ? mem[word_a] : 8'h00;
      end
    end

    assign rdata_o[8*g +: 8] = rd_q;
  end
endmodule

// File: rtl/cfgbar_decoder.sv
module cfgbar_decoder
  import cfgbar_pkg::*;
#(
  parameter int unsigned REG_WORDS = 256
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic [63:0] req_addr_i,
  input  logic [9:0]  req_len_i,
  input  logic        req_we_i,
  input  logic [31:0] req_wdata_i,
  input  logic [3:0]  req_be_i,
  input  logic [1:0]  bar_mode_i,
  input  logic [31:0] bar0_base_i,
  input  logic [31:0] bar1_base_i,
  input  logic        bar_pair64_i,
  input  logic [63:0] bar_limit_i,
  output logic        hit_o,
  output logic [9:0]  reg_idx_o,
  output logic        rd_stb_o,
  output logic        wr_stb_o,
  output logic [31:0] rdata_o,
  output logic        len_err_o
);
  logic match;
  dec_s dec;

  cfgbar_match u_match (
    .addr_i    (req_addr_i),
    .mode_i    (bar_mode_i),
    .base_lo_i (bar0_base_i),
    .base_hi_i (bar1_base_i),
    .pair64_i  (bar_pair64_i),
    .limit_i   (bar_limit_i),
    .hit_o     (match)
  );

  cfgbar_req u_req (
    .valid_i (req_valid_i),
    .we_i    (req_we_i),
    .len_i   (req_len_i),
    .match_i (match),
    .ofs_i   (req_addr_i[OFS_W-1:0]),
    .dec_o   (dec)
  );

  cfgbar_regfile #(.WORDS(REG_WORDS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (dec.rd),
    .wr_en_i (dec.wr),
    .idx_i   (dec.idx),
    .wdata_i (req_wdata_i),
    .be_i    (req_be_i),
    .rdata_o (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o     <= 1'b0;
      rd_stb_o  <= 1'b0;
      wr_stb_o  <= 1'b0;
      reg_idx_o <= '0;
      len_err_o <= 1'b0;
    end else begin
      hit_o    <= dec.hit;
      rd_stb_o <= dec.rd;
      wr_stb_o <= dec.wr;
      if (dec.hit) reg_idx_o <= dec.idx;
      if (dec.bad_len) len_err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/cfgbar_decoder_chk.sv
module cfgbar_decoder_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [63:0] req_addr_i,
  input logic [9:0]  req_len_i,
  input logic        req_we_i,
  input logic [1:0]  bar_mode_i,
  input logic [31:0] bar1_base_i,
  input logic        bar_pair64_i,
  input logic        hit_o,
  input logic [9:0]  reg_idx_o,
  input logic        rd_stb_o,
  input logic        wr_stb_o,
  input logic        len_err_o
);
  p_mode_gate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(bar_mode_i) == 2'b01);
  p_upper_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !$past(bar_pair64_i)) |-> $past(req_addr_i[63:32]) == 32'h0);
  p_upper_pair_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && $past(bar_pair64_i)) |-> $past(req_addr_i[63:32]) == $past(bar1_base_i));
  p_idx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> reg_idx_o == $past(req_addr_i[11:2]));
  p_excl_stb_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_stb_o && wr_stb_o));
  p_stb_dir_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> $past(req_we_i) && $past(req_valid_i));
  p_len_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_o || wr_stb_o) |-> $past(req_len_i) == 10'd1);
  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_err_o |=> len_err_o);
  p_miss_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> !rd_stb_o && !wr_stb_o && (len_err_o == $past(len_err_o)));
endmodule

bind cfgbar_decoder cfgbar_decoder_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_addr_i   (req_addr_i),
  .req_len_i    (req_len_i),
  .req_we_i     (req_we_i),
  .bar_mode_i   (bar_mode_i),
  .bar1_base_i  (bar1_base_i),
  .bar_pair64_i (bar_pair64_i),
  .hit_o        (hit_o),
  .reg_idx_o    (reg_idx_o),
  .rd_stb_o     (rd_stb_o),
  .wr_stb_o     (wr_stb_o),
  .len_err_o    (len_err_o)
);

// File: tb/cfgbar_decoder_bench.sv
`timescale 1ns/1ps
module cfgbar_decoder_bench;
  localparam int unsigned WORDS = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [63:0] addr = '0;
  logic [9:0]  len = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [3:0]  be = '0;
  logic [1:0]  mode = 2'b01;
  logic [31:0] bar0 = '0;
  logic [31:0] bar1 = '0;
  logic        pair = 1'b0;
  logic [63:0] limit = '0;
  logic        hit, rd_stb, wr_stb, len_err;
  logic [9:0]  idx;
  logic [31:0] rdata;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model [WORDS];
  logic        exp_err;

  always #2.5 clk = ~clk;

  cfgbar_decoder #(.REG_WORDS(WORDS)) u_cfgbar_decoder (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_addr_i(addr),
    .req_len_i(len), .req_we_i(we), .req_wdata_i(wdata), .req_be_i(be),
    .bar_mode_i(mode), .bar0_base_i(bar0), .bar1_base_i(bar1),
    .bar_pair64_i(pair), .bar_limit_i(limit), .hit_o(hit), .reg_idx_o(idx),
    .rd_stb_o(rd_stb), .wr_stb_o(wr_stb), .rdata_o(rdata), .len_err_o(len_err)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_hit(input logic [63:0] a);
    logic up_ok;
    up_ok = pair ? (a[63:32] == bar1) : (a[63:32] == 32'h0);
    return (mode == 2'b01) && (a[31:12] == bar0[31:12]) && up_ok;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    valid = 1'b0;
    for (int w = 0; w < WORDS; w++) model[w] = 32'h0;
    exp_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic req(input logic [63:0] a, input logic [9:0] l, input logic w,
                     input logic [31:0] d, input logic [3:0] b, input string tag);
    logic        eh, erd, ewr;
    logic [9:0]  ei;
    logic [31:0] ed;
    @(negedge clk);
    addr = a; len = l; we = w; wdata = d; be = b; valid = 1'b1;
    eh  = exp_hit(a);
    erd = eh && (l == 10'd1) && !w;
    ewr = eh && (l == 10'd1) && w;
    ei  = a[11:2];
    ed  = (32'(ei) < WORDS) ? model[ei] : 32'h0;
    if (eh && l != 10'd1) exp_err = 1'b1;
    @(posedge clk);
    #1;
    valid = 1'b0;
    chk(hit === eh, {tag, " hit"}, 64'(hit), 64'(eh));
    chk(rd_stb === erd, {tag, " rd_stb"}, 64'(rd_stb), 64'(erd));
    chk(wr_stb === ewr, {tag, " wr_stb"}, 64'(wr_stb), 64'(ewr));
    chk(len_err === exp_err, {tag, " len_err"}, 64'(len_err), 64'(exp_err));
    if (eh) chk(idx === ei, {tag, " idx"}, 64'(idx), 64'(ei));
    if (erd) chk(rdata === ed, {tag, " rdata"}, 64'(rdata), 64'(ed));
    if (ewr && 32'(ei) < WORDS)
      for (int k = 0; k < 4; k++) if (b[k]) model[ei][8*k +: 8] = d[8*k +: 8];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [63:0] base;
    void'($urandom(32'd20240611));
    bar0 = 32'h8000_0000;
    do_reset();
    // R12 reset state
    chk(hit === 1'b0 && rd_stb === 1'b0 && wr_stb === 1'b0, "R12 strobes", 64'({hit, rd_stb, wr_stb}), 0);
    chk(len_err === 1'b0 && idx === 10'd0 && rdata === 32'd0, "R12 outputs", 64'({len_err, idx, rdata}), 0);
    base = {32'h0, bar0};
    req(base + 64'h000, 10'd1, 1'b0, 32'h0, 4'hF, "R12 word0 zero");
    // R6 / R10 write then read
    req(base + 64'h014, 10'd1, 1'b1, 32'hA1B2_C3D4, 4'hF, "R6 write idx5");
    req(base + 64'h014, 10'd1, 1'b0, 32'h0, 4'h0, "R10 read idx5 be0");
    // R9 byte lanes
    req(base + 64'h014, 10'd1, 1'b1, 32'h1122_3344, 4'b0010, "R9 lane1");
    req(base + 64'h014, 10'd1, 1'b0, 32'h0, 4'hF, "R9 readback");
    req(base + 64'h014, 10'd1, 1'b1, 32'h5566_7788, 4'b1001, "R9 lanes0_3");
    req(base + 64'h014, 10'd1, 1'b0, 32'h0, 4'hF, "R9 readback2");
    // R2 aperture edges, base low bits ignored
    bar0 = 32'h8000_0ABC;
    req(base + 64'hFFC, 10'd1, 1'b0, 32'h0, 4'hF, "R2 top offset");
    req(base + 64'h1000, 10'd1, 1'b1, 32'hDEAD, 4'hF, "R2 past end");
    req(base - 64'h4, 10'd1, 1'b1, 32'hDEAD, 4'hF, "R2 below base");
    // R3 limit ignored
    limit = 64'h0;
    req(base + 64'h020, 10'd1, 1'b1, 32'h0BAD_F00D, 4'hF, "R3 limit zero");
    limit = 64'hFFFF_FFFF_FFFF_FFFF;
    req(base + 64'h020, 10'd1, 1'b0, 32'h0, 4'hF, "R3 limit all ones");
    req(base + 64'h2000, 10'd1, 1'b0, 32'h0, 4'hF, "R3 wide limit miss");
    limit = 64'h0;
    // R4 upper bits in 32-bit mode
    req(base + 64'h1_0000_0000, 10'd1, 1'b1, 32'h1, 4'hF, "R4 upper nonzero");
    // R5 paired base
    pair = 1'b1; bar1 = 32'h0000_0012;
    req({32'h12, bar0[31:12], 12'h030}, 10'd1, 1'b1, 32'hCAFE_0001, 4'hF, "R5 paired hit");
    req({32'h12, bar0[31:12], 12'h030}, 10'd1, 1'b0, 32'h0, 4'hF, "R5 paired read");
    req({32'h00, bar0[31:12], 12'h030}, 10'd1, 1'b0, 32'h0, 4'hF, "R5 upper zero miss");
    pair = 1'b0;
    // R1 other modes
    mode = 2'b00; req(base + 64'h014, 10'd1, 1'b1, 32'hFFFF, 4'hF, "R1 mode00");
    mode = 2'b10; req(base + 64'h014, 10'd1, 1'b0, 32'h0, 4'hF, "R1 mode10");
    mode = 2'b11; req(base + 64'h014, 10'd1, 1'b1, 32'hFFFF, 4'hF, "R1 mode11");
    mode = 2'b01; req(base + 64'h014, 10'd1, 1'b0, 32'h0, 4'hF, "R1 unchanged");
    // R11 beyond depth
    req(base + 64'h4B0, 10'd1, 1'b1, 32'h7777_7777, 4'hF, "R11 write high");
    req(base + 64'h4B0, 10'd1, 1'b0, 32'h0, 4'hF, "R11 read high");
    req(base + 64'hFFC, 10'd1, 1'b0, 32'h0, 4'hF, "R11 read top");

    // R7 same-cycle hit and illegal length
    do_reset();
    req(base + 64'h040, 10'd1, 1'b1, 32'h1357_9BDF, 4'hF, "R7 setup write");
    req(base + 64'h040, 10'd2, 1'b1, 32'hFFFF_FFFF, 4'hF, "R7 len2 write");
    req(base + 64'h040, 10'd1, 1'b0, 32'h0, 4'hF, "R7 unchanged read");
    req(base + 64'h040, 10'd0, 1'b0, 32'h0, 4'hF, "R7 len0 read");
    req(base + 64'h5000, 10'd3, 1'b1, 32'h0, 4'hF, "R8 miss bad len");
    req(base + 64'h044, 10'd1, 1'b1, 32'h2468, 4'hF, "R7 sticky good");

    // random traffic, fresh error state
    do_reset();
    req(base + 64'h5000, 10'd2, 1'b0, 32'h0, 4'hF, "R8 miss no err");
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] a;
      logic [9:0]  l;
      mode  = ($urandom % 4 != 0) ? 2'b01 : 2'($urandom);
      pair  = 1'($urandom);
      bar1  = $urandom % 4;
      limit = {$urandom, $urandom};
      if (n % 500 == 0) bar0 = $urandom;
      a[63:32] = ($urandom % 8 != 0) ? (pair ? bar1 : 32'h0) : ($urandom % 4);
      a[31:12] = ($urandom % 8 != 0) ? bar0[31:12] : bar0[31:12] + 20'($urandom % 3) - 20'd1;
      a[11:0]  = ($urandom % 4 != 0) ? 12'($urandom % 1024) : 12'($urandom);
      l = ($urandom % 10 != 0) ? 10'd1 : 10'($urandom % 4);
      req(a, l, 1'($urandom), $urandom, 4'($urandom), "R1_R11 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule